// File: doc/BRIEF.md
# Ripple-Through Register-Chain FIFO

A first-in first-out buffer of 32 words of 8 bits. It is built as a chain of registers, and each register carries its own occupancy bit. A word enters at the head stage on the rising edge of a load strobe. When the load strobe falls, the word moves one stage per clock toward the tail. It stops behind the nearest occupied stage.

The word that reaches the tail stage is presented on the data output, and an output-ready status is raised. A rising edge on the dump strobe retires that word. While the dump strobe is high, the tail stage accepts nothing. When the dump strobe falls, the chain closes up behind the tail.

Both strobes are asynchronous to the system clock. Each one is synchronized through two flops and edge-detected before it is used. An approximate half-full flag reports occupancy with loose thresholds. When the output enable is low, the output reads all ones and a drive-enable output is low. A synchronous active-low master reset empties the chain.

Top module: `ripple_fifo`

## Requirements
- R1: After a clock edge with `rst_n` low, `in_full`, `out_ready` and `half_full` are 0 and, with `out_en` high, `dout` is 0x00; a reset in the middle of operation discards every stored word.
- R2: A rising edge of `load_stb` (after synchronization) while the head stage is empty captures `din` into the head stage and raises `in_full`.
- R3: While `load_stb` stays high, the head word does not move and `in_full` stays 1; after `load_stb` falls, the word leaves the head stage and `in_full` returns to 0 unless all 32 stages hold data.
- R4: A word moves one stage per clock into the next stage when that stage is empty. It enters the tail stage only while `dump_stb` is low, and then `out_ready` rises and `dout` shows the word within 40 clocks of the load strobe falling.
- R5: A rising edge of `dump_stb` while `out_ready` is 1 retires the tail word and drops `out_ready`. While `dump_stb` stays high, `out_ready` stays 0. After it falls, the next word takes the tail.
- R6: Words leave in the order they were loaded, under any interleaving of loads and dumps.
- R7: With 32 words stored, `in_full` and `out_ready` are both 1. A further load edge neither overwrites the head word nor adds a word.
- R8: A dump edge while the chain is empty changes nothing: `out_ready` stays 0 and the next loaded word is the next word delivered.
- R9: `half_full` is 1 exactly when 15 or more words are stored. It is therefore 0 at 14 words or fewer and 1 at 16 or more.
- R10: With `out_en` low, `dout` reads 0xFF and `dout_drive` is 0. When `out_en` returns high, `dout` shows the tail word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| din | input | 8 | Data to load |
| load_stb | input | 1 | Load strobe: rising edge captures, falling edge releases the head word |
| dump_stb | input | 1 | Dump strobe: rising edge retires the tail word, falling edge refills the tail |
| out_en | input | 1 | Output enable |
| dout | output | 8 | Tail word, or 0xFF when disabled |
| dout_drive | output | 1 | High when `dout` is meant to be driven |
| in_full | output | 1 | Head stage occupied |
| out_ready | output | 1 | Tail stage occupied |
| half_full | output | 1 | Approximate half-full flag |

## Verification
The fall-through path is exercised in three ways:
- Single loads into an empty chain check the latency and the head-to-tail movement.
- A fill to 32 followed by a full drain checks ordering at both limits and the half-full edge between 14 and 15 words.
- A long random mix of loads and dumps checks the order when bubbles open in the middle of the chain.

Holding each strobe high for many cycles separates the level gating from the edge actions. A load on a full chain checks that the head word is never overwritten, and a dump on an empty chain checks that it is ignored. A reset in mid-fill and a toggle of the output enable check that stored data is cleared or preserved as required.

// File: rtl/ripple_fifo_pkg.sv
// Shared types for the ripple-through FIFO.
package ripple_fifo_pkg;

    // Synchronized strobe: its current level and a one-cycle rising-edge pulse.
    typedef struct packed {
        logic level;
        logic rise;
    } strobe_t;

endpackage

// File: rtl/strobe_sync.sv
// strobe_sync
// Brings an asynchronous strobe into the clock domain through SYNC_STAGES
// flops. It then reports the synchronized level and a one-cycle pulse on
// each rising edge.
// Assumes each strobe level is held for at least two clocks.
module strobe_sync
    import ripple_fifo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pin,
    output strobe_t st
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Shift the raw pin through the synchronizer and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
            prev_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    // Report the level and the rising edge.
    always_comb begin
        st.level = chain_q[SYNC_STAGES-1];
        st.rise  = chain_q[SYNC_STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/ripple_stage.sv
// ripple_stage
// One register of the chain: a data word and its occupancy bit.
// Assumes the controller never asserts take_in and give_out in the same
// cycle. Loading takes priority if it ever does.
module ripple_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_in,
    input  logic             give_out,
    input  logic [WIDTH-1:0] in_data,
    output logic             valid_o,
    output logic [WIDTH-1:0] data_o
);
    // Capture a word, or give up occupancy when the word moves on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (take_in) begin
            valid_o <= 1'b1;
            data_o  <= in_data;
        end else if (give_out) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/occupancy_flag.sv
// occupancy_flag
// Counts stored words and drives a registered half-full flag. The flag is
// set at HALF_ON words or more.
// Assumes inc and dec each add or remove exactly one occupied stage.
module occupancy_flag #(
    parameter int DEPTH   = 32,
    parameter int HALF_ON = 15,
    parameter int COUNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic [DEPTH-1:0] valid_vec,
    output logic             half_full
);
    localparam logic [COUNT_W-1:0] HALF_C = COUNT_W'(HALF_ON);

    logic [COUNT_W-1:0] count_q;
    logic [COUNT_W-1:0] count_d;

    // Work out the next count from the accept and retire events.
    always_comb begin
        count_d = count_q;
        if (inc && !dec) count_d = count_q + 1'b1;
        if (dec && !inc) count_d = count_q - 1'b1;
    end

    // Register the count and the flag so that the flag never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            half_full <= 1'b0;
        end else begin
            count_q   <= count_d;
            half_full <= (count_d >= HALF_C);
        end
    end

    // R9: the count tracks the occupied stages of the chain.
    assert_count_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q == COUNT_W'($countones(valid_vec)));

    // R9: the flag follows the stored-word threshold.
    assert_half_threshold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        half_full == (COUNT_W'($countones(valid_vec)) >= HALF_C));
endmodule

// File: rtl/ripple_fifo.sv
// ripple_fifo
// Fall-through FIFO built as a chain of DEPTH registers of WIDTH bits.
// A load edge places a word at the head, and the word ripples one stage per
// clock toward the tail. A dump edge retires the tail word.
// The head word is held while the load strobe is high, and the tail accepts
// nothing while the dump strobe is high.
// Assumes the strobes are held at least two clocks at each level.
module ripple_fifo
    import ripple_fifo_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int WIDTH       = 8,
    parameter int HALF_ON     = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             load_stb,
    input  logic             dump_stb,
    input  logic             out_en,
    output logic [WIDTH-1:0] dout,
    output logic             dout_drive,
    output logic             in_full,
    output logic             out_ready,
    output logic             half_full
);
    localparam int TAIL = DEPTH - 1;

    strobe_t          ld_st;
    strobe_t          dp_st;
    logic [DEPTH-1:0] vld;
    logic [WIDTH-1:0] stg [DEPTH];
    logic [DEPTH-2:0] adv;
    logic             load_take;
    logic             tail_pop;

    strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_load_sync (
        .clk(clk), .rst_n(rst_n), .pin(load_stb), .st(ld_st));
    strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_dump_sync (
        .clk(clk), .rst_n(rst_n), .pin(dump_stb), .st(dp_st));

    // Decide which words step forward: into an empty stage, with the head
    // held by the load level and the tail closed by the dump level.
    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            adv[i] = vld[i] && !vld[i+1];
            if (i == 0 && ld_st.level)
                adv[i] = 1'b0;
            if (i == DEPTH - 2 && dp_st.level)
                adv[i] = 1'b0;
        end
    end

    // Accept a load only into an empty head; retire only an occupied tail.
    always_comb begin
        load_take = ld_st.rise && !vld[0];
        tail_pop  = dp_st.rise && vld[TAIL];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            ripple_stage #(.WIDTH(WIDTH)) u_stage (
                .clk(clk), .rst_n(rst_n), .take_in(load_take), .give_out(adv[0]),
                .in_data(din), .valid_o(vld[0]), .data_o(stg[0]));
        end else if (g == TAIL) begin : g_tail
            ripple_stage #(.WIDTH(WIDTH)) u_stage (
                .clk(clk), .rst_n(rst_n), .take_in(adv[g-1]), .give_out(tail_pop),
                .in_data(stg[g-1]), .valid_o(vld[g]), .data_o(stg[g]));
        end else begin : g_mid
            ripple_stage #(.WIDTH(WIDTH)) u_stage (
                .clk(clk), .rst_n(rst_n), .take_in(adv[g-1]), .give_out(adv[g]),
                .in_data(stg[g-1]), .valid_o(vld[g]), .data_o(stg[g]));
        end
    end

    occupancy_flag #(.DEPTH(DEPTH), .HALF_ON(HALF_ON)) u_occ (
        .clk(clk), .rst_n(rst_n), .inc(load_take), .dec(tail_pop),
        .valid_vec(vld), .half_full(half_full));

    // Present the status bits and the tail word, or all ones when disabled.
    always_comb begin
        in_full    = vld[0];
        out_ready  = vld[TAIL];
        dout_drive = out_en;
        dout       = out_en ? stg[TAIL] : '1;
    end

    // R1: a reset cycle leaves the chain empty.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (vld == '0));

    // R3: a held load strobe keeps the head word in place.
    assert_head_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[0] && ld_st.level) |=> vld[0]);

    // R7: a load edge on an occupied head leaves its word untouched.
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[0] && ld_st.rise) |=> (vld[0] && $stable(stg[0])));

    // R5: a dump edge on an occupied tail empties it.
    assert_tail_retired_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_st.rise && vld[TAIL]) |=> !vld[TAIL]);

    // R5: an empty tail stays empty while the dump strobe is high.
    assert_tail_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_st.level && !vld[TAIL]) |=> !vld[TAIL]);

    // R4: an occupied stage stays occupied unless its word is passed on.
    assert_word_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[1] && vld[2]) |=> vld[1]);
endmodule

// File: tb/tb_ripple_fifo.sv
module tb_ripple_fifo;
    localparam int DEPTH  = 32;
    localparam int SETTLE = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       load_stb = 1'b0;
    logic       dump_stb = 1'b0;
    logic       out_en = 1'b1;
    logic [7:0] dout;
    logic       dout_drive, in_full, out_ready, half_full;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model_q[$];

    ripple_fifo dut (
        .clk(clk), .rst_n(rst_n), .din(din), .load_stb(load_stb),
        .dump_stb(dump_stb), .out_en(out_en), .dout(dout),
        .dout_drive(dout_drive), .in_full(in_full), .out_ready(out_ready),
        .half_full(half_full));

    always #5 clk = ~clk;

    function automatic logic exp_half(int cnt);
        return cnt >= 15;
    endfunction

    function automatic logic exp_full(int cnt);
        return cnt == DEPTH;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk(req, "in_full", 32'(in_full), 32'(exp_full(model_q.size())));
        chk(req, "out_ready", 32'(out_ready), 32'(model_q.size() != 0));
        chk(req, "half_full", 32'(half_full), 32'(exp_half(model_q.size())));
        if (model_q.size() != 0)
            chk(req, "dout", 32'(dout), 32'(model_q[0]));
    endtask

    task automatic push(logic [7:0] d);
        din = d;
        load_stb = 1'b1;
        tick(4);
        load_stb = 1'b0;
        tick(SETTLE);
        if (model_q.size() < DEPTH)
            model_q.push_back(d);
    endtask

    task automatic pop();
        dump_stb = 1'b1;
        tick(4);
        dump_stb = 1'b0;
        tick(SETTLE);
        if (model_q.size() != 0)
            void'(model_q.pop_front());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        model_q.delete();
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: state after reset.
        chk("R1", "in_full", 32'(in_full), 0);
        chk("R1", "out_ready", 32'(out_ready), 0);
        chk("R1", "half_full", 32'(half_full), 0);
        chk("R1", "dout", 32'(dout), 0);

        // R2 and R3: a held load keeps the word at the head.
        din = 8'h5A;
        load_stb = 1'b1;
        tick(12);
        chk("R2", "in_full held", 32'(in_full), 1);
        chk("R3", "out_ready while held", 32'(out_ready), 0);
        load_stb = 1'b0;
        tick(40);
        model_q.push_back(8'h5A);
        // R4: fall-through within 40 clocks.
        chk("R4", "out_ready after fall", 32'(out_ready), 1);
        chk("R4", "dout after fall", 32'(dout), 32'h5A);
        chk("R3", "in_full after release", 32'(in_full), 0);

        // R5: a held dump keeps the tail empty.
        push(8'hA1);
        check_state("R6");
        dump_stb = 1'b1;
        tick(12);
        chk("R5", "out_ready while dump held", 32'(out_ready), 0);
        dump_stb = 1'b0;
        tick(SETTLE);
        void'(model_q.pop_front());
        chk("R5", "next word at tail", 32'(dout), 32'hA1);
        check_state("R5");
        pop();
        check_state("R5");

        // R8: a dump on an empty chain is ignored.
        pop();
        chk("R8", "out_ready empty dump", 32'(out_ready), 0);
        push(8'h3C);
        chk("R8", "word after empty dump", 32'(dout), 32'h3C);
        check_state("R8");
        pop();

        // R7 and R9: fill to 32, checking the flag at each step.
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(8'h10 + i));
            chk("R9", "half_full on fill", 32'(half_full), 32'(exp_half(i + 1)));
        end
        check_state("R7");
        push(8'hEE);
        check_state("R7");
        // R7: the extra load must not appear; drain and check order.
        for (int i = 0; i < DEPTH; i++) begin
            chk("R7", "drain order", 32'(dout), 32'(8'h10 + i));
            pop();
            chk("R9", "half_full on drain", 32'(half_full), 32'(exp_half(DEPTH - 1 - i)));
        end
        chk("R7", "empty after drain", 32'(out_ready), 0);

        // R10: output enable.
        push(8'h77);
        out_en = 1'b0;
        tick(1);
        chk("R10", "dout disabled", 32'(dout), 32'hFF);
        chk("R10", "drive disabled", 32'(dout_drive), 0);
        out_en = 1'b1;
        tick(1);
        chk("R10", "dout re-enabled", 32'(dout), 32'h77);
        chk("R10", "drive enabled", 32'(dout_drive), 1);

        // R1: reset in the middle of operation.
        for (int i = 0; i < 5; i++) push(8'(8'hC0 + i));
        do_reset();
        chk("R1", "mid reset out_ready", 32'(out_ready), 0);
        chk("R1", "mid reset in_full", 32'(in_full), 0);
        chk("R1", "mid reset dout", 32'(dout), 0);
        push(8'h99);
        chk("R1", "first word after reset", 32'(dout), 32'h99);
        pop();

        // R6: random mix of loads and dumps.
        for (int i = 0; i < 500; i++) begin
            if (($urandom % 100) < 55)
                push(8'($urandom));
            else
                pop();
            check_state("R6");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule